// File: doc/BRIEF.md
# SPI Controller Interrupt Status Logic

This block holds the interrupt state of an SPI master whose transmit and receive paths each use a byte-wide FIFO of 32 entries. The datapath outside the block provides the occupancy counts, the full flags and one-cycle event pulses. From these the block builds a seven-bit status word. Three of its bits are sticky event flags. The other four follow the FIFO state in every cycle. The receive-level bit compares against a threshold register and so does the transmit-level bit.

Software reaches the block through a simple write port. A write to the status address clears sticky flags where the data has a 1. The enable and disable addresses set or clear bits of the interrupt mask. Two further addresses load the thresholds. A combinational read port returns the status, the mask and the thresholds. The single interrupt line is a registered level. It is high when any status bit is also set in the mask.

Top module: `spi_irq_status`

## Requirements
- R1: The status word has this bit layout: bit 0 receive overflow, bit 1 mode fail, bit 2 transmit count below the TX threshold, bit 3 transmit FIFO full, bit 4 receive count at or above the RX threshold, bit 5 receive FIFO full, bit 6 transmit underflow. The bits of the read data above bit 6 always read 0.
- R2: Bits 0, 1 and 6 are sticky. Each one sets in the cycle after its event pulse and stays set until a write to address 0 has a 1 in that bit position. A write with 0 in that position leaves the bit alone.
- R3: When an event pulse and a clearing write to the same sticky bit fall in one cycle, the bit stays set.
- R4: Bits 2, 3, 4 and 5 follow the current counts, flags and thresholds combinationally, in the same cycle. A write of 1 to them at address 0 has no effect.
- R5: A write to address 1 ORs the data into the mask. A write to address 2 clears the data's set bits from the mask. A write to address 3 (the mask's read address) leaves the mask unchanged.
- R6: The interrupt output is registered. After each clock edge it equals the OR of mask AND status as they stood before that edge, so it trails any status or mask change by one cycle.
- R7: After reset the mask is 0, both thresholds are 1 and the interrupt is low. With empty FIFOs the status is 0x04. Addresses 4 and 5 load the TX and RX thresholds from the low bits of the write data, and read back at those addresses.
- R8: Reads at address 1 and address 2 return 0. A read at address 0 returns the status and a read at address 3 returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | DATA_W | Combinational read data |
| txCount | input | CNT_W | Transmit FIFO occupancy |
| rxCount | input | CNT_W | Receive FIFO occupancy |
| txFull | input | 1 | Transmit FIFO full flag |
| rxFull | input | 1 | Receive FIFO full flag |
| txUnderflowEvt | input | 1 | Transmit underflow event pulse |
| rxOverflowEvt | input | 1 | Receive overflow event pulse |
| modeFailEvt | input | 1 | Mode fail event pulse |
| status | output | 7 | Current status word |
| mask | output | 7 | Current interrupt mask |
| irq | output | 1 | Registered interrupt level |

## Verification
The level bits are combinational, so the bench checks them a moment after it changes a count or a threshold-related input, with no clock edge in between. A sticky flag or a mask write takes effect at the next edge, so it is checked at the falling edge that follows. The interrupt line adds one more register, so each interrupt check first confirms the old level right after the causing change and then the new level one cycle later. That catches a design that is too early and one that is too late.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ADDR_W  = 3;
  localparam int STAT_W  = 7;
  localparam int STICKY_N = 3;

  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DISABLE = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TXTHR   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_RXTHR   = 3'd5;

  // status bit positions
  localparam int BIT_RXOVF  = 0;
  localparam int BIT_MFAIL  = 1;
  localparam int BIT_TXLOW  = 2;
  localparam int BIT_TXFULL = 3;
  localparam int BIT_RXLVL  = 4;
  localparam int BIT_RXFULL = 5;
  localparam int BIT_TXUND  = 6;

  typedef struct packed {
    logic clrSticky;
    logic setMask;
    logic clrMask;
    logic ldTxThr;
    logic ldRxThr;
  } strobe_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (wrAddr)
        ADDR_STATUS:  stb.clrSticky = 1'b1;
        ADDR_ENABLE:  stb.setMask   = 1'b1;
        ADDR_DISABLE: stb.clrMask   = 1'b1;
        ADDR_TXTHR:   stb.ldTxThr   = 1'b1;
        ADDR_RXTHR:   stb.ldRxThr   = 1'b1;
        default:      stb = '0;
      endcase
    end
  end

  // R5: at most one register action per write
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  // R5: no action without a write strobe
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (stb == '0));
endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txFull,
  input  logic              rxFull,
  input  logic              txUnderflowEvt,
  input  logic              rxOverflowEvt,
  input  logic              modeFailEvt,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic [STICKY_N-1:0] stickyQ;
  logic [STICKY_N-1:0] evtVec;
  logic [STICKY_N-1:0] clrVec;
  logic [STAT_W-1:0]   statusW;
  logic [STAT_W-1:0]   maskQ;
  logic [CNT_W-1:0]    txThrQ;
  logic [CNT_W-1:0]    rxThrQ;
  logic                irqQ;

  assign evtVec = {txUnderflowEvt, modeFailEvt, rxOverflowEvt};
  assign clrVec = stb.clrSticky ? {wrData[BIT_TXUND], wrData[BIT_MFAIL], wrData[BIT_RXOVF]}
                                : '0;

  for (genvar g = 0; g < STICKY_N; g++) begin : gSticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          stickyQ[g] <= 1'b0;
      else if (evtVec[g]) stickyQ[g] <= 1'b1;
      else if (clrVec[g]) stickyQ[g] <= 1'b0;
    end
  end

  always_comb begin
    statusW             = '0;
    statusW[BIT_RXOVF]  = stickyQ[0];
    statusW[BIT_MFAIL]  = stickyQ[1];
    statusW[BIT_TXLOW]  = txCount < txThrQ;
    statusW[BIT_TXFULL] = txFull;
    statusW[BIT_RXLVL]  = rxCount >= rxThrQ;
    statusW[BIT_RXFULL] = rxFull;
    statusW[BIT_TXUND]  = stickyQ[2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      txThrQ <= CNT_W'(1);
      rxThrQ <= CNT_W'(1);
      irqQ   <= 1'b0;
    end else begin
      if (stb.setMask) maskQ <= maskQ | wrData[STAT_W-1:0];
      if (stb.clrMask) maskQ <= maskQ & ~wrData[STAT_W-1:0];
      if (stb.ldTxThr) txThrQ <= wrData[CNT_W-1:0];
      if (stb.ldRxThr) rxThrQ <= wrData[CNT_W-1:0];
      irqQ <= |(maskQ & statusW);
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_STATUS: rdData = DATA_W'(statusW);
      ADDR_MASK:   rdData = DATA_W'(maskQ);
      ADDR_TXTHR:  rdData = DATA_W'(txThrQ);
      ADDR_RXTHR:  rdData = DATA_W'(rxThrQ);
      default:     rdData = '0;
    endcase
  end

  assign status = statusW;
  assign mask   = maskQ;
  assign irq    = irqQ;

  // R2: a sticky flag without a clearing 1 stays set
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stickyQ & $past(stickyQ & ~clrVec)) == $past(stickyQ & ~clrVec)));
  // R3: an event always leaves its flag set, even against a clear
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stickyQ & $past(evtVec)) == $past(evtVec)));
  // R5: enabled bits appear in the mask
  a_r5_enable_sets: assert property (@(posedge clk) disable iff (!rstN)
    stb.setMask |=> ((maskQ & $past(wrData[STAT_W-1:0])) == $past(wrData[STAT_W-1:0])));
  // R5: a mask change needs an enable or disable write
  a_r5_mask_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setMask || stb.clrMask) |=> $stable(maskQ));
  // R6: interrupt trails masked status by one cycle
  a_r6_irq_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(|(mask & status))));
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txFull,
  input  logic              rxFull,
  input  logic              txUnderflowEvt,
  input  logic              rxOverflowEvt,
  input  logic              modeFailEvt,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  strobe_t stb;

  spi_irq_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .stb    (stb)
  );

  spi_irq_datapath #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .wrData         (wrData),
    .rdAddr         (rdAddr),
    .rdData         (rdData),
    .txCount        (txCount),
    .rxCount        (rxCount),
    .txFull         (txFull),
    .rxFull         (rxFull),
    .txUnderflowEvt (txUnderflowEvt),
    .rxOverflowEvt  (rxOverflowEvt),
    .modeFailEvt    (modeFailEvt),
    .status         (status),
    .mask           (mask),
    .irq            (irq)
  );
endmodule

// File: tb/tb_spi_irq_status.sv
module tb_spi_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [2:0] wrAddr;
  logic [7:0] wrData;
  logic [2:0] rdAddr;
  logic [7:0] rdData;
  logic [CNT_W-1:0] txCount, rxCount;
  logic       txFull, rxFull;
  logic       txUnderflowEvt, rxOverflowEvt, modeFailEvt;
  logic [6:0] status, mask;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_status dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .rxFull(rxFull), .txUnderflowEvt(txUnderflowEvt),
    .rxOverflowEvt(rxOverflowEvt), .modeFailEvt(modeFailEvt),
    .status(status), .mask(mask), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R7 reset status", {1'b0, status}, 8'h04);
    check("R7 reset mask", {1'b0, mask}, 8'h00);
    check("R7 reset irq", {7'b0, irq}, 8'h00);
    rd(3'd4, v); check("R7 reset tx threshold", v, 8'h01);
    rd(3'd5, v); check("R7 reset rx threshold", v, 8'h01);
    rd(3'd0, v); check("R1 status read upper bit", v, 8'h04);
  endtask

  task automatic testLevels();
    logic [7:0] v;
    rxCount = 6'd1; #1;
    check("R4 rx at threshold 1", {1'b0, status}, 8'h14);
    wr(3'd5, 8'd5);
    rd(3'd5, v); check("R7 rx threshold load", v, 8'h05);
    rxCount = 6'd4; #1;
    check("R4 rx below threshold 5", {1'b0, status}, 8'h04);
    rxCount = 6'd5; #1;
    check("R4 rx equal threshold 5", {1'b0, status}, 8'h14);
    txCount = 6'd3; #1;
    check("R4 tx above threshold", {1'b0, status}, 8'h10);
    wr(3'd4, 8'd4);
    check("R4 tx below loaded threshold", {1'b0, status}, 8'h14);
    txFull = 1'b1; rxFull = 1'b1; #1;
    check("R1 full flags positions", {1'b0, status}, 8'h3C);
    wr(3'd0, 8'h3C);
    check("R4 clear ignored on level bits", {1'b0, status}, 8'h3C);
    txFull = 1'b0; rxFull = 1'b0; txCount = '0; rxCount = '0; #1;
    check("R4 levels back to empty", {1'b0, status}, 8'h04);
  endtask

  task automatic pulse(input int which);
    if (which == 0) rxOverflowEvt = 1'b1;
    if (which == 1) modeFailEvt = 1'b1;
    if (which == 2) txUnderflowEvt = 1'b1;
    step();
    rxOverflowEvt = 1'b0; modeFailEvt = 1'b0; txUnderflowEvt = 1'b0;
  endtask

  task automatic testSticky();
    pulse(0);
    check("R2 rx overflow sets bit0", {1'b0, status}, 8'h05);
    step(); step();
    check("R2 rx overflow holds", {1'b0, status}, 8'h05);
    wr(3'd0, 8'h42);
    check("R2 clear of other bits keeps bit0", {1'b0, status}, 8'h05);
    wr(3'd0, 8'h01);
    check("R2 clear bit0", {1'b0, status}, 8'h04);
    pulse(1);
    check("R2 mode fail sets bit1", {1'b0, status}, 8'h06);
    pulse(2);
    check("R2 underflow sets bit6", {1'b0, status}, 8'h46);
    wr(3'd0, 8'h42);
    check("R2 clear bits 1 and 6", {1'b0, status}, 8'h04);
  endtask

  task automatic testCollision();
    txUnderflowEvt = 1'b1; wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h40;
    step();
    txUnderflowEvt = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R3 event beats clear on fresh bit", {1'b0, status}, 8'h44);
    txUnderflowEvt = 1'b1; wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h40;
    step();
    txUnderflowEvt = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R3 event beats clear on set bit", {1'b0, status}, 8'h44);
    wr(3'd0, 8'h40);
    check("R3 later clear works", {1'b0, status}, 8'h04);
  endtask

  task automatic testMask();
    logic [7:0] v;
    wr(3'd1, 8'h41);
    check("R5 enable sets", {1'b0, mask}, 8'h41);
    wr(3'd1, 8'h02);
    check("R5 enable ORs", {1'b0, mask}, 8'h43);
    wr(3'd2, 8'h01);
    check("R5 disable clears", {1'b0, mask}, 8'h42);
    wr(3'd3, 8'hFF);
    check("R5 mask address write ignored", {1'b0, mask}, 8'h42);
    rd(3'd3, v); check("R8 mask read", v, 8'h42);
    rd(3'd1, v); check("R8 enable reads zero", v, 8'h00);
    rd(3'd2, v); check("R8 disable reads zero", v, 8'h00);
    check("R6 masked bits clear so irq low", {7'b0, irq}, 8'h00);
    wr(3'd2, 8'h7F);
  endtask

  task automatic testIrq();
    pulse(2);
    step();
    check("R6 unmasked event no irq", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h40);
    check("R6 irq not yet after enable", {7'b0, irq}, 8'h00);
    step();
    check("R6 irq one cycle after enable", {7'b0, irq}, 8'h01);
    wr(3'd2, 8'h40);
    check("R6 irq holds in disable cycle", {7'b0, irq}, 8'h01);
    step();
    check("R6 irq drops after disable", {7'b0, irq}, 8'h00);
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h10);
    step();
    check("R6 rx level masked but low", {7'b0, irq}, 8'h00);
    rxCount = 6'd5; #1;
    check("R6 irq lags level change", {7'b0, irq}, 8'h00);
    step();
    check("R6 irq from level bit", {7'b0, irq}, 8'h01);
    rxCount = 6'd0;
    step();
    check("R6 irq follows level down", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    txCount = '0; rxCount = '0; txFull = 1'b0; rxFull = 1'b0;
    txUnderflowEvt = 1'b0; rxOverflowEvt = 1'b0; modeFailEvt = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
    testReset();
    testLevels();
    testSticky();
    testCollision();
    testMask();
    testIrq();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule